// File: doc/BRIEF.md
# Segmented-DAC Successive-Approximation Controller

This block sequences the bit decisions of a 7-bit successive-approximation sub-converter. The converter's capacitor DAC is split into two parts. The upper three bits steer a unary array of seven equal elements. The lower four bits steer a binary-weighted array. A single pulse on the start input launches a conversion. This pulse is the same one that closes the converter's sampling switch.

Two flop chains carry the work. A one-hot token chain marks the bit under trial on each step. A per-bit decision chain captures the comparator's answer in the step where that bit is tried. The present code is the OR of the decided bits and the trial token, and the block drives it on `code_o`. The upper field of that code is decoded into thermometer lines for the unary array, so those lines move as each of the three top bits is tried and settled. One clock after the last decision, `done_o` pulses for one cycle to show that the residue can be handed to the next stage. All outputs then hold until the next start.

Top module: `sar_seg_ctrl`

## Requirements
- R1: While `rst_n` is low, `code_o`, `therm_o` and `done_o` are all 0.
- R2: In the cycle after `start_i` is sampled high, `code_o` equals 1000000 (only bit 6 set) and `done_o` is 0.
- R3: During a conversion, the bit under trial reads 1, every bit below it reads 0, and every bit above it shows its decision.
- R4: Each bit is tried in turn from bit 6 down to bit 0. At the edge that ends a bit's step, the bit keeps the value of `cmp_i`: it stays 1 when `cmp_i` is 1 and it is cleared when `cmp_i` is 0. The final code therefore equals the comparator answers, first answer in bit 6.
- R5: `done_o` is high for exactly one cycle. That cycle is the one following the 8th rising edge, counting the edge that samples `start_i` as the 1st.
- R6: After the `done_o` cycle, `code_o` and `therm_o` hold their values until the next start.
- R7: `therm_o` has its lowest n lines high and the rest low, where n = `code_o[6:4]` read as an unsigned number (0 to 7).
- R8: A start that arrives during a conversion abandons it. The next cycle shows 1000000 and a fresh 8-step conversion follows.
- R9: `cmp_i` has no effect on `code_o` while no conversion is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample/start pulse, launches a conversion |
| cmp_i | input | 1 | Comparator decision for the bit under trial |
| code_o | output | 7 | Trial/decided binary code, bit 6 most significant |
| therm_o | output | 7 | Unary switch controls decoded from code_o[6:4] |
| done_o | output | 1 | One-cycle pulse: conversion finished, residue ready |

## Verification
The bench builds the block with its default widths: seven bits, of which three are segmented. At this size every one of the 128 comparator answer patterns can be driven, and the code, the thermometer lines and the done flag are compared on every step of every conversion. This sweep reaches all eight thermometer levels, both decision outcomes at every bit position, and hold behaviour after each final code. Separate runs cover a restart part-way through a conversion, reset asserted during a conversion, and comparator activity while the block is idle.

// File: rtl/sar_seg_pkg.sv
package sar_seg_pkg;

  // Number of unary lines needed to represent a segment of seg bits.
  function automatic int unsigned unary_lines(input int unsigned seg);
    return (32'd1 << seg) - 32'd1;
  endfunction

  // Width of a counter able to count up to limit.
  function automatic int unsigned count_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/sar_token_chain.sv
// One-hot approximation token: a load at start, a right shift per step,
// and a trailing stage that marks the residue-ready cycle.
module sar_token_chain #(
  parameter int unsigned NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [NBITS-1:0] trial_o,
  output logic             fin_o
);

  logic [NBITS-1:0] tok_q, tok_d;
  logic             fin_q, fin_d;
  logic             tok_en;

  // Next state
  always_comb begin
    tok_en = start_i | (|tok_q) | fin_q;
    if (start_i) begin
      tok_d = {1'b1, {(NBITS-1){1'b0}}};
      fin_d = 1'b0;
    end else begin
      tok_d = tok_q >> 1;
      fin_d = tok_q[0];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
      fin_q <= 1'b0;
    end else if (tok_en) begin
      tok_q <= tok_d;
      fin_q <= fin_d;
    end
  end

  assign trial_o = tok_q;
  assign fin_o   = fin_q;

endmodule

// File: rtl/sar_decision_chain.sv
// One decision flop per bit: cleared by start, loaded with the comparator
// answer in the step where the token sits on that bit, held otherwise.
module sar_decision_chain #(
  parameter int unsigned NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic [NBITS-1:0] trial_i,
  output logic [NBITS-1:0] dec_o
);

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic dec_q, dec_d, dec_en;

    always_comb begin
      dec_en = start_i | trial_i[b];
      dec_d  = ~start_i & cmp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dec_q <= 1'b0;
      end else if (dec_en) begin
        dec_q <= dec_d;
      end
    end

    assign dec_o[b] = dec_q;
  end

endmodule

// File: rtl/sar_therm_decoder.sv
// Binary-to-thermometer decode of the segmented upper field.
module sar_therm_decoder #(
  parameter int unsigned SEG_BITS = 3,
  parameter int unsigned LINES    = 7
) (
  input  logic [SEG_BITS-1:0] bin_i,
  output logic [LINES-1:0]    therm_o
);

  logic [31:0] level;
  assign level = {{(32-SEG_BITS){1'b0}}, bin_i};

  for (genvar j = 0; j < LINES; j++) begin : g_line
    assign therm_o[j] = (level > j);
  end

endmodule

// File: rtl/sar_seg_ctrl.sv
module sar_seg_ctrl
  import sar_seg_pkg::*;
#(
  parameter int unsigned NBITS    = 7,
  parameter int unsigned SEG_BITS = 3,
  localparam int unsigned LINES   = unary_lines(SEG_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] code_o,
  output logic [LINES-1:0] therm_o,
  output logic             done_o
);

  logic [NBITS-1:0] trial;
  logic [NBITS-1:0] dec;
  logic             fin;
  logic [NBITS-1:0] code;

  sar_token_chain #(.NBITS(NBITS)) u_tok (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .trial_o (trial),
    .fin_o   (fin)
  );

  sar_decision_chain #(.NBITS(NBITS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cmp_i   (cmp_i),
    .trial_i (trial),
    .dec_o   (dec)
  );

  // Bits below the token are still cleared in dec, so OR gives the trial code.
  assign code = dec | trial;

  sar_therm_decoder #(.SEG_BITS(SEG_BITS), .LINES(LINES)) u_therm (
    .bin_i   (code[NBITS-1 -: SEG_BITS]),
    .therm_o (therm_o)
  );

  assign code_o = code;
  assign done_o = fin;

endmodule

// File: rtl/sar_seg_ctrl_chk.sv
module sar_seg_ctrl_chk
  import sar_seg_pkg::*;
#(
  parameter int unsigned NBITS    = 7,
  parameter int unsigned SEG_BITS = 3,
  localparam int unsigned LINES   = unary_lines(SEG_BITS),
  localparam int unsigned CW      = count_width(NBITS + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cmp_i,
  input logic [NBITS-1:0] code_o,
  input logic [LINES-1:0] therm_o,
  input logic             done_o
);

  // Step counter: 1 after the start edge, saturates past the done step.
  logic [CW-1:0] cnt_q;
  logic          idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b1;
    end else begin
      if (start_i) begin
        cnt_q <= CW'(1);
      end else if (cnt_q != '0 && int'(cnt_q) <= int'(NBITS) + 1) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (start_i) begin
        idle_q <= 1'b0;
      end else if (done_o) begin
        idle_q <= 1'b1;
      end
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (code_o == {1'b1, {(NBITS-1){1'b0}}}) && !done_o); // R2

  AST_BIT_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && int'(cnt_q) <= int'(NBITS) && !start_i)
    |=> code_o[int'(NBITS) - int'($past(cnt_q))] == $past(cmp_i)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> int'(cnt_q) == int'(NBITS) + 1); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !start_i && !done_o) |=> $stable(code_o) && $stable(therm_o)); // R6

  AST_THERM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm_o) == int'(code_o[NBITS-1 -: SEG_BITS])); // R7

  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_o & (therm_o + 1'b1)) == '0); // R7

endmodule

bind sar_seg_ctrl sar_seg_ctrl_chk #(.NBITS(NBITS), .SEG_BITS(SEG_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .cmp_i   (cmp_i),
  .code_o  (code_o),
  .therm_o (therm_o),
  .done_o  (done_o)
);

// File: tb/sim_sar_seg_ctrl.sv
`timescale 1ns/1ps
module sim_sar_seg_ctrl;
  localparam int NB  = 7;
  localparam int SEG = 3;
  localparam int TW  = (1 << SEG) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_i = 1'b0;
  logic [NB-1:0] code_o;
  logic [TW-1:0] therm_o;
  logic          done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sar_seg_ctrl #(.NBITS(NB), .SEG_BITS(SEG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .code_o(code_o), .therm_o(therm_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int therm_exp(input int code);
    int lvl;
    lvl = code >> (NB - SEG);
    return (1 << lvl) - 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Start pulse; on return the first trial step is on the outputs.
  task automatic launch();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(code_o == 7'h40, "R2 start code", int'(code_o), 64);
    chk(done_o == 1'b0, "R2 done low", int'(done_o), 0);
  endtask

  // Drive steps from bit hi down to 0 with answers from target.
  task automatic steps(input int target, input int hi, input bit full);
    for (int b = hi; b >= 0; b--) begin
      int mask_hi, exp;
      cmp_i = target[b];
      tick();
      mask_hi = ((1 << NB) - 1) & ~((1 << b) - 1);
      exp = (target & mask_hi) | ((b > 0) ? (1 << (b - 1)) : 0);
      if (full) begin
        chk(int'(code_o) == exp, "R3/R4 step code", int'(code_o), exp);
        chk(int'(therm_o) == therm_exp(exp), "R7 therm", int'(therm_o), therm_exp(exp));
        chk(done_o == (b == 0), "R5 done timing", int'(done_o), int'(b == 0));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(code_o == '0, "R1 reset code", int'(code_o), 0);
    chk(therm_o == '0, "R1 reset therm", int'(therm_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    tick();

    // Exhaustive sweep of comparator answer patterns
    for (int t = 0; t < (1 << NB); t++) begin
      launch();
      steps(t, NB - 1, 1'b1);
      cmp_i = ~cmp_i;
      tick();
      chk(done_o == 1'b0, "R5 done one cycle", int'(done_o), 0);
      chk(int'(code_o) == t, "R6 final hold", int'(code_o), t);
      chk(int'(therm_o) == therm_exp(t), "R6 therm hold", int'(therm_o), therm_exp(t));
      for (int k = 0; k < 2; k++) begin
        cmp_i = ~cmp_i;
        tick();
        chk(int'(code_o) == t, "R9 idle cmp ignored", int'(code_o), t);
      end
    end

    // Restart in the middle of a conversion
    launch();
    steps(7'h7F, NB - 1, 1'b0);
    launch();
    launch();
    steps(7'h7F, NB - 1, 1'b0);
    launch();
    steps(7'h7F, NB - 1, 1'b0);
    // Abandon after three bits then run a full fresh conversion
    launch();
    for (int b = NB - 1; b >= NB - 3; b--) begin
      cmp_i = 1'b1;
      tick();
    end
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(code_o == 7'h40, "R8 restart code", int'(code_o), 64);
    steps(7'h15, NB - 1, 1'b1);
    tick();
    chk(int'(code_o) == 7'h15, "R8 restart result", int'(code_o), 21);

    // Reset during a conversion
    launch();
    steps(7'h7F, NB - 1, 1'b0);
    launch();
    cmp_i = 1'b1;
    tick();
    rst_n = 1'b0;
    #1;
    chk(code_o == '0, "R1 mid reset code", int'(code_o), 0);
    chk(therm_o == '0, "R1 mid reset therm", int'(therm_o), 0);
    chk(done_o == 1'b0, "R1 mid reset done", int'(done_o), 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk(code_o == '0, "R9 no run after reset", int'(code_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule